// File: doc/BRIEF.md
# Binary-to-ASCII Decimal Frame Sender

This block watches an 11-bit unsigned binary input and reacts whenever the sampled value differs from the one seen on the previous clock. It latches the new value and converts it to four BCD digits with an iterative shift-and-add-3 converter that handles one input bit per cycle. It then offers the result to a downstream byte transmitter as a five-character ASCII frame: the thousands, hundreds, tens and ones digits, and then a `;` terminator.

Each character is held on `txData` with `txValid` high until the transmitter returns a single-cycle `txDone`. The block then moves to the next character. A change that arrives while a conversion or a frame is in progress does not disturb the current frame. The change is remembered, and exactly one further frame, carrying the input value present when the terminator is acknowledged, follows at once. Every register is clocked by `clk` alone. `txDone` is sampled as an ordinary synchronous input.

Top module: `binAsciiFrameSender`

## Requirements
- R1: While `rst` is high and after it is released, `txValid` stays low until `binIn` changes. Reset loads the change detector from the current input, so no frame follows reset.
- R2: A frame is exactly five characters, in a fixed order: thousands, hundreds, tens, ones, then the terminator. Each digit is sent as 8'h30 plus its BCD value, and the terminator is 8'h3B.
- R3: The four digits are the decimal representation of the latched value over the full range 0 to 2047, including 0, 999, 1000 and 2047. The leading (thousands) character is therefore always 8'h30, 8'h31 or 8'h32.
- R4: While `txValid` is high and `txDone` is low, `txValid` stays high and `txData` holds its value. Each cycle with `txDone` high advances the frame by exactly one character.
- R5: When the terminator is acknowledged and no change is pending, `txValid` falls in the next cycle. It stays low for as long as `binIn` is stable.
- R6: Any number of input changes during a conversion or a frame leaves the characters of the current frame unchanged. Those changes produce exactly one further frame, which carries the latest input value.
- R7: Counting the rising edge that first samples a changed input as edge 1, `txValid` rises after rising edge 12. This is one edge to latch the value and eleven conversion steps.
- R8: `txDone` pulses while `txValid` is low have no effect. A later frame still starts with the thousands character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every register uses its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| binIn | input | 11 | Unsigned binary value to be reported |
| txData | output | 8 | ASCII character offered to the transmitter |
| txValid | output | 1 | High while `txData` holds a character waiting to be sent |
| txDone | input | 1 | One-cycle pulse from the transmitter marking the end of a character |

## Verification
The bound checker watches the handshake on every cycle:
- characters are held stable until they are acknowledged;
- only digit codes or the terminator appear on `txData`;
- the leading character is in range;
- the internal character selector stays one-hot;
- the line goes quiet after an acknowledged terminator and after reset.

Only the bench's scenarios can show the rest:
- that the digits match the decimal value at the range edges;
- that the exact latency is twelve edges;
- that changes during a frame yield precisely one follow-up frame with the final value;
- that stray `txDone` pulses are ignored.

// File: rtl/bin_ascii_pkg.sv
package bin_ascii_pkg;
  localparam int BIN_W      = 11;
  localparam int DIGITS     = 4;
  localparam int FRAME_LEN  = DIGITS + 1;
  localparam int BCD_W      = 4 * DIGITS;
  localparam logic [7:0] ASCII_ZERO = 8'h30;
  localparam logic [7:0] TERM_CHAR  = 8'h3B;

  // strobes from control to datapath
  typedef struct packed {
    logic                 startConv;  // latch input and begin conversion
    logic [FRAME_LEN-1:0] charSel;    // one-hot character pick, 0 = none
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic changeSeen;
    logic convDone;
  } dpStatus_t;
endpackage

// File: rtl/binAsciiDatapath.sv
module binAsciiDatapath
  import bin_ascii_pkg::*;
#(
  parameter int BinW   = BIN_W,
  parameter int Digits = DIGITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BinW-1:0]   binIn,
  input  ctrlStrobe_t       ctrl,
  output dpStatus_t         status,
  output logic [7:0]        txData
);
  localparam int BcdW   = 4 * Digits;
  localparam int CountW = $clog2(BinW + 1);
  localparam int FrameW = Digits + 1;
  localparam logic [CountW-1:0] LastStep = CountW'(BinW - 1);

  // change detector
  logic [BinW-1:0] prevValue;
  always_ff @(posedge clk) begin
    prevValue <= binIn;
  end
  assign status.changeSeen = !rst && (binIn != prevValue);

  // iterative shift-and-add-3 converter
  logic [BinW-1:0]   binShift;
  logic [BcdW-1:0]   bcdWork;
  logic [BcdW-1:0]   bcdAdjusted;
  logic [BcdW-1:0]   bcdNext;
  logic [BcdW-1:0]   digitReg;
  logic [CountW-1:0] stepCount;
  logic              busy;

  for (genvar d = 0; d < Digits; d++) begin : g_adjust
    logic [3:0] nib;
    assign nib = bcdWork[4*d +: 4];
    assign bcdAdjusted[4*d +: 4] = (nib >= 4'd5) ? nib + 4'd3 : nib;
  end

  assign bcdNext         = {bcdAdjusted[BcdW-2:0], binShift[BinW-1]};
  assign status.convDone = busy && (stepCount == LastStep);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      stepCount <= '0;
      binShift  <= '0;
      bcdWork   <= '0;
      digitReg  <= '0;
    end else if (ctrl.startConv) begin
      busy      <= 1'b1;
      stepCount <= '0;
      binShift  <= binIn;
      bcdWork   <= '0;
    end else if (busy) begin
      bcdWork   <= bcdNext;
      binShift  <= {binShift[BinW-2:0], 1'b0};
      stepCount <= stepCount + 1'b1;
      if (stepCount == LastStep) begin
        busy     <= 1'b0;
        digitReg <= bcdNext;
      end
    end
  end

  // character mux: selector bit 0 picks the most significant digit
  always_comb begin
    txData = 8'h00;
    for (int i = 0; i < Digits; i++) begin
      if (ctrl.charSel[i]) begin
        txData = txData | (ASCII_ZERO + {4'h0, digitReg[4*(Digits-1-i) +: 4]});
      end
    end
    if (ctrl.charSel[FrameW-1]) begin
      txData = txData | TERM_CHAR;
    end
  end
endmodule

// File: rtl/binAsciiControl.sv
module binAsciiControl
  import bin_ascii_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  dpStatus_t   status,
  input  logic        txDone,
  output ctrlStrobe_t ctrl,
  output logic        txValid
);
  typedef enum logic [1:0] {ST_IDLE, ST_CONV, ST_SEND} seqState_t;

  seqState_t            state;
  logic [FRAME_LEN-1:0] charSel;
  logic                 pending;
  logic                 lastAck;
  logic                 startNow;

  assign lastAck  = (state == ST_SEND) && charSel[FRAME_LEN-1] && txDone;
  assign startNow = ((state == ST_IDLE) && status.changeSeen) ||
                    (lastAck && (pending || status.changeSeen));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      charSel <= '0;
      pending <= 1'b0;
    end else begin
      if (startNow) begin
        pending <= 1'b0;
      end else if (status.changeSeen) begin
        pending <= 1'b1;
      end

      if (startNow) begin
        state   <= ST_CONV;
        charSel <= '0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_CONV: begin
            if (status.convDone) begin
              state   <= ST_SEND;
              charSel <= FRAME_LEN'(1);
            end
          end
          ST_SEND: begin
            if (lastAck) begin
              state   <= ST_IDLE;
              charSel <= '0;
            end else if (txDone) begin
              charSel <= {charSel[FRAME_LEN-2:0], 1'b0};
            end
          end
          default: begin
            state   <= ST_IDLE;
            charSel <= '0;
          end
        endcase
      end
    end
  end

  assign ctrl.startConv = startNow;
  assign ctrl.charSel   = charSel;
  assign txValid        = |charSel;
endmodule

// File: rtl/binAsciiFrameSender.sv
module binAsciiFrameSender
  import bin_ascii_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [BIN_W-1:0] binIn,
  output logic [7:0]       txData,
  output logic             txValid,
  input  logic             txDone
);
  ctrlStrobe_t ctrlBus;
  dpStatus_t   statusBus;

  binAsciiDatapath #(.BinW(BIN_W), .Digits(DIGITS)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .binIn  (binIn),
    .ctrl   (ctrlBus),
    .status (statusBus),
    .txData (txData)
  );

  binAsciiControl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .status  (statusBus),
    .txDone  (txDone),
    .ctrl    (ctrlBus),
    .txValid (txValid)
  );
endmodule

// File: rtl/binAsciiFrameSender_checker.sv
module binAsciiFrameSender_checker
  import bin_ascii_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic [7:0]           txData,
  input logic                 txValid,
  input logic                 txDone,
  input logic [FRAME_LEN-1:0] charSel
);
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (txValid && !txDone) |=> (txValid && $stable(txData)));

  p_char_code_r2: assert property (@(posedge clk) disable iff (rst)
    txValid |-> ((txData >= 8'h30 && txData <= 8'h39) || txData == 8'h3B));

  p_lead_digit_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(txValid) |-> (txData >= 8'h30 && txData <= 8'h32));

  p_quiet_after_term_r5: assert property (@(posedge clk) disable iff (rst)
    (txValid && txDone && txData == 8'h3B) |=> !txValid);

  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(charSel));

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> !txValid);
endmodule

bind binAsciiFrameSender binAsciiFrameSender_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .txData  (txData),
  .txValid (txValid),
  .txDone  (txDone),
  .charSel (ctrlBus.charSel)
);

// File: tb/binAsciiFrameSender_bench.sv
module binAsciiFrameSender_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] binIn = 11'd1234;
  logic [7:0]  txData;
  logic        txValid;
  logic        txDone = 1'b0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  binAsciiFrameSender u_binAsciiFrameSender (
    .clk(clk), .rst(rst), .binIn(binIn),
    .txData(txData), .txValid(txValid), .txDone(txDone)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic logic [7:0] expChar(input int value, input int idx);
    case (idx)
      0: return 8'h30 + 8'((value / 1000) % 10);
      1: return 8'h30 + 8'((value / 100) % 10);
      2: return 8'h30 + 8'((value / 10) % 10);
      3: return 8'h30 + 8'(value % 10);
      default: return 8'h3B;
    endcase
  endfunction

  // receives one frame; optionally changes input while holding char chgIdx
  task automatic expectFrame(input int value, input string req, input int chgIdx,
                             input logic [10:0] chgA, input logic [10:0] chgB);
    for (int i = 0; i < 5; i++) begin
      int wait_n = 0;
      while (!txValid && wait_n < 100) begin
        @(negedge clk);
        wait_n++;
      end
      check(txValid, {req, " valid arrives"}, int'(txValid), 1);
      check(txData == expChar(value, i), {req, " char"}, int'(txData), int'(expChar(value, i)));
      for (int h = 0; h < 3; h++) begin
        logic [7:0] held = txData;
        if (i == chgIdx && h == 0) binIn = chgA;
        if (i == chgIdx && h == 1) binIn = chgB;
        @(negedge clk);
        check(txValid && txData == held, "R4 hold until done", int'(txData), int'(held));
      end
      txDone = 1'b1;
      @(negedge clk);
      txDone = 1'b0;
    end
  endtask

  task automatic checkQuiet(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txValid) seen++;
    end
    check(seen == 0, req, seen, 0);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check(!txValid, "R1 low in reset", int'(txValid), 0);
    rst = 1'b0;
    checkQuiet(30, "R1 no frame after reset");
  endtask

  task automatic testLatency(input logic [10:0] v);
    int n = 0;
    binIn = v;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!txValid && n < 50);
    check(n == 12, "R7 latency edges", n, 12);
    expectFrame(int'(v), "R2 R3 frame", -1, v, v);
    checkQuiet(20, "R5 quiet after frame");
  endtask

  task automatic testValue(input logic [10:0] v);
    @(negedge clk);
    binIn = v;
    expectFrame(int'(v), "R3 decimal digits", -1, v, v);
    checkQuiet(20, "R5 quiet after frame");
  endtask

  task automatic testChangeMidFrame();
    @(negedge clk);
    binIn = 11'd321;
    expectFrame(321, "R6 current frame intact", 1, 11'd1500, 11'd1987);
    expectFrame(1987, "R6 follow-up frame latest", -1, 11'd1987, 11'd1987);
    checkQuiet(40, "R6 exactly one follow-up");
  endtask

  task automatic testChangeDuringConv();
    @(negedge clk);
    binIn = 11'd42;
    repeat (4) @(negedge clk);
    binIn = 11'd777;
    expectFrame(42, "R6 conv frame intact", -1, 11'd777, 11'd777);
    expectFrame(777, "R6 follow-up after conv change", -1, 11'd777, 11'd777);
    checkQuiet(40, "R6 single follow-up");
  endtask

  task automatic testStrayDone();
    for (int i = 0; i < 4; i++) begin
      txDone = 1'b1;
      @(negedge clk);
      txDone = 1'b0;
      @(negedge clk);
    end
    checkQuiet(10, "R8 stray done ignored");
    binIn = 11'd1066;
    expectFrame(1066, "R8 frame starts at thousands", -1, 11'd1066, 11'd1066);
    checkQuiet(20, "R5 quiet after frame");
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testLatency(11'd0);
    testValue(11'd2047);
    testValue(11'd1000);
    testValue(11'd999);
    testValue(11'd5);
    testChangeMidFrame();
    testChangeDuringConv();
    testStrayDone();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule